// File: doc/BRIEF.md
# Coherent Multi-Byte Snapshot Read Registers

This block puts several live 24-bit quantities, such as waveform samples or RMS results, on an 8-bit processor read bus. Each quantity takes three byte addresses. A processor that must read a value spread over three bytes needs all three to come from one instant. The block provides that by taking a snapshot of the whole live value when the most significant byte is read. The middle and least significant bytes are then read from that snapshot, so software must read the high byte first.

A small group of interrupt-status bytes follows the channel addresses. Each status byte is sampled from the live status inputs on the clock edge that reads it. Read data is registered and stays stable between reads. The logic that produces the live values and status bits is outside this block.

Top module: `snap_read_regs`

## Requirements
- R1: Channel c has three byte addresses: 3c returns bits [7:0], 3c+1 returns bits [15:8] and 3c+2 returns bits [23:16]. Read data appears on `rd_data` one clock after the cycle in which `rd_en` is sampled high.
- R2: A read of the high-byte address of a channel copies that channel's entire live 24-bit input into its snapshot on the same edge. The data returned is bits [23:16] of the newly captured value.
- R3: A read of the low or middle byte returns the byte from the most recent snapshot of that channel, not from the live input.
- R4: Reads of the low or middle byte never change any snapshot.
- R5: Each channel has its own snapshot. A high-byte read of one channel leaves the snapshots of every other channel unchanged.
- R6: After reset every snapshot is zero and `rd_data` is zero.
- R7: Status byte k is at address 3*NUM_CH+k. A read of it returns bits [8k+7:8k] of `irq_status` as sampled on the reading edge, and later changes of `irq_status` do not alter the returned byte.
- R8: While `rd_en` is low, `rd_data` holds its previous value.
- R9: A read of an address at or above 3*NUM_CH+STAT_BYTES returns zero and changes no snapshot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rd_en | input | 1 | Read strobe, one cycle per read |
| rd_addr | input | ADDR_W | Byte address of the read |
| live_data | input | NUM_CH*24 | Live values; channel c at bits [24c+23:24c] |
| irq_status | input | STAT_BYTES*8 | Live interrupt-status bits |
| rd_data | output | 8 | Registered read data |

## Verification
The bench changes the live inputs between the high-byte read and the reads of the lower bytes. A design that reads the lower bytes from the live value therefore returns the wrong bytes. It also reads the lower bytes before any high read, which exposes a snapshot that is not cleared by reset. After each capture it reads the other channels, so a capture strobe decoded for the wrong channel, or one that leaks into other channels, corrupts a neighbouring snapshot. Status bytes are changed right after each read, and unmapped addresses are swept, which catches a status read that is not sampled on its edge and out-of-range reads that return data or disturb a snapshot.

// File: rtl/snap_pkg.sv
package snap_pkg;
    localparam int BYTE_W       = 8;
    localparam int BYTES_PER_CH = 3;

    typedef enum logic [1:0] {
        SEL_LO   = 2'd0,
        SEL_MID  = 2'd1,
        SEL_HI   = 2'd2,
        SEL_NONE = 2'd3
    } byte_sel_e;
endpackage

// File: rtl/snap_channel.sv
module snap_channel #(
    parameter int DATA_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_i,
    input  logic [DATA_W-1:0] live_i,
    output logic [DATA_W-1:0] snap_o
);
    typedef struct packed {
        logic [DATA_W-1:0] snap;
    } chan_state_t;

    chan_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (cap_i) begin
            s_d.snap = live_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign snap_o = s_q.snap;

    AST_SNAP_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        cap_i |=> snap_o == $past(live_i)); // R2
    AST_SNAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_i |=> $stable(snap_o)); // R4
endmodule

// File: rtl/snap_addr_decode.sv
module snap_addr_decode
    import snap_pkg::*;
#(
    parameter int NUM_CH     = 3,
    parameter int STAT_BYTES = 2,
    parameter int ADDR_W     = 4,
    parameter int CH_IDX_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
    parameter int ST_IDX_W   = (STAT_BYTES > 1) ? $clog2(STAT_BYTES) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                rd_en_i,
    input  logic [ADDR_W-1:0]   addr_i,
    output logic                hit_o,
    output logic                is_stat_o,
    output byte_sel_e           bsel_o,
    output logic [CH_IDX_W-1:0] ch_idx_o,
    output logic [ST_IDX_W-1:0] st_idx_o,
    output logic [NUM_CH-1:0]   cap_o
);
    localparam int CH_SPAN  = BYTES_PER_CH * NUM_CH;
    localparam int MAP_SIZE = CH_SPAN + STAT_BYTES;

    int a_int;
    int ch_int;
    int pos_int;

    always_comb begin
        a_int     = int'(addr_i);
        ch_int    = 0;
        pos_int   = 0;
        hit_o     = 1'b0;
        is_stat_o = 1'b0;
        bsel_o    = SEL_NONE;
        ch_idx_o  = '0;
        st_idx_o  = '0;
        if (a_int < CH_SPAN) begin
            hit_o    = 1'b1;
            ch_int   = a_int / BYTES_PER_CH;
            pos_int  = a_int % BYTES_PER_CH;
            ch_idx_o = CH_IDX_W'(ch_int);
            bsel_o   = byte_sel_e'(pos_int[1:0]);
        end else if (a_int < MAP_SIZE) begin
            hit_o     = 1'b1;
            is_stat_o = 1'b1;
            st_idx_o  = ST_IDX_W'(a_int - CH_SPAN);
        end
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_cap
        assign cap_o[c] = rd_en_i && hit_o && !is_stat_o &&
                          (bsel_o == SEL_HI) && (ch_int == c);
    end

    AST_ONE_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cap_o)); // R5
    AST_NO_CAP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en_i |-> cap_o == '0); // R4
endmodule

// File: rtl/snap_read_regs.sv
module snap_read_regs
    import snap_pkg::*;
#(
    parameter int NUM_CH     = 3,
    parameter int STAT_BYTES = 2,
    parameter int ADDR_W     = 4,
    parameter int DATA_W     = 24
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       rd_en,
    input  logic [ADDR_W-1:0]          rd_addr,
    input  logic [NUM_CH*DATA_W-1:0]   live_data,
    input  logic [STAT_BYTES*8-1:0]    irq_status,
    output logic [7:0]                 rd_data
);
    localparam int CH_IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
    localparam int ST_IDX_W = (STAT_BYTES > 1) ? $clog2(STAT_BYTES) : 1;
    localparam int MAP_SIZE = BYTES_PER_CH * NUM_CH + STAT_BYTES;

    initial begin
        if (DATA_W != BYTES_PER_CH * BYTE_W) $error("DATA_W must be three bytes");
        if (MAP_SIZE > (1 << ADDR_W)) $error("ADDR_W too small for the map");
    end

    logic                hit;
    logic                is_stat;
    byte_sel_e           bsel;
    logic [CH_IDX_W-1:0] ch_idx;
    logic [ST_IDX_W-1:0] st_idx;
    logic [NUM_CH-1:0]   cap;
    logic [DATA_W-1:0]   snap_w [NUM_CH];
    logic [DATA_W-1:0]   live_w [NUM_CH];

    snap_addr_decode #(
        .NUM_CH     (NUM_CH),
        .STAT_BYTES (STAT_BYTES),
        .ADDR_W     (ADDR_W),
        .CH_IDX_W   (CH_IDX_W),
        .ST_IDX_W   (ST_IDX_W)
    ) u_decode (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_en_i   (rd_en),
        .addr_i    (rd_addr),
        .hit_o     (hit),
        .is_stat_o (is_stat),
        .bsel_o    (bsel),
        .ch_idx_o  (ch_idx),
        .st_idx_o  (st_idx),
        .cap_o     (cap)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        assign live_w[c] = live_data[c*DATA_W +: DATA_W];
        snap_channel #(.DATA_W(DATA_W)) u_chan (
            .clk    (clk),
            .rst_n  (rst_n),
            .cap_i  (cap[c]),
            .live_i (live_w[c]),
            .snap_o (snap_w[c])
        );
    end

    typedef struct packed {
        logic [7:0] rd_data;
    } rd_state_t;

    rd_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (rd_en) begin
            s_d.rd_data = '0;
            if (hit && is_stat) begin
                s_d.rd_data = irq_status[st_idx*8 +: 8];
            end else if (hit) begin
                case (bsel)
                    SEL_LO:  s_d.rd_data = snap_w[ch_idx][7:0];
                    SEL_MID: s_d.rd_data = snap_w[ch_idx][15:8];
                    SEL_HI:  s_d.rd_data = live_w[ch_idx][23:16];
                    default: s_d.rd_data = '0;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign rd_data = s_q.rd_data;

    AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data)); // R8
    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !hit) |=> rd_data == 8'h00); // R9
    AST_HI_MATCHES_SNAP: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && hit && !is_stat && bsel == SEL_HI) |=>
        rd_data == snap_w[$past(ch_idx)][23:16]); // R2
endmodule

// File: tb/snap_read_regs_bench.sv
module snap_read_regs_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NCH  = 3;
    localparam int NST  = 2;
    localparam int AW   = 4;
    localparam int STAT_BASE = 3 * NCH;
    localparam int MAPSZ = STAT_BASE + NST;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               rd_en = 1'b0;
    logic [AW-1:0]      rd_addr = '0;
    logic [NCH*24-1:0]  live_data = '0;
    logic [NST*8-1:0]   irq_status = '0;
    logic [7:0]         rd_data;

    logic [23:0] model_snap [NCH];
    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    snap_read_regs #(
        .NUM_CH(NCH), .STAT_BYTES(NST), .ADDR_W(AW), .DATA_W(24)
    ) u_snap_read_regs (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_addr(rd_addr),
        .live_data(live_data), .irq_status(irq_status), .rd_data(rd_data)
    );

    function automatic logic [23:0] pat(input int i, input int c);
        int v;
        v = (i + 1) * 32'h000B3C5D + c * 32'h005A1E07 + (i << (c + 3));
        return v[23:0];
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic do_read(input int addr, output logic [7:0] val);
        @(negedge clk);
        rd_en   = 1'b1;
        rd_addr = AW'(addr);
        @(negedge clk);
        rd_en   = 1'b0;
        val     = rd_data;
    endtask

    task automatic set_live(input int i);
        for (int c = 0; c < NCH; c++) live_data[c*24 +: 24] = pat(i, c);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        logic [7:0] v;
        logic [7:0] held;
        for (int c = 0; c < NCH; c++) model_snap[c] = '0;
        set_live(99);
        irq_status = 16'hA55A;
        repeat (3) @(negedge clk);
        check("R6 rd_data after reset", rd_data, 8'h00);
        rst_n = 1'b1;
        // R6: snapshots start at zero, lower bytes read before any capture
        for (int c = 0; c < NCH; c++) begin
            do_read(3*c, v);     check("R6 low byte after reset", v, 8'h00);
            do_read(3*c + 1, v); check("R6 mid byte after reset", v, 8'h00);
        end
        for (int i = 0; i < 16; i++) begin
            set_live(i);
            for (int c = 0; c < NCH; c++) begin
                // R3: lower bytes still come from the older snapshot
                do_read(3*c, v);     check("R3 low before high", v, model_snap[c][7:0]);
                do_read(3*c + 1, v); check("R3 mid before high", v, model_snap[c][15:8]);
                do_read(3*c + 2, v);
                check("R2 high byte capture", v, live_data[c*24 + 16 +: 8]);
                model_snap[c] = live_data[c*24 +: 24];
                set_live(i + 40);
                // R1 R4: lower bytes of captured value after live changes
                do_read(3*c + 1, v); check("R1 mid from snapshot", v, model_snap[c][15:8]);
                do_read(3*c, v);     check("R1 low from snapshot", v, model_snap[c][7:0]);
                do_read(3*c + 1, v); check("R4 mid after lower reads", v, model_snap[c][15:8]);
                // R5: other channels keep their own snapshot
                for (int o = 0; o < NCH; o++) begin
                    if (o != c) begin
                        do_read(3*o, v); check("R5 other channel unchanged", v, model_snap[o][7:0]);
                    end
                end
                set_live(i);
            end
            // R7: status bytes sampled on the read edge, then frozen
            for (int k = 0; k < NST; k++) begin
                irq_status = 16'(i * 16'h1D3B + k * 16'h0F71);
                do_read(STAT_BASE + k, v);
                check("R7 status byte", v, irq_status[k*8 +: 8]);
                held = irq_status[k*8 +: 8];
                irq_status = ~irq_status;
                repeat (2) @(negedge clk);
                check("R7 status byte latched", rd_data, held);
            end
            // R8: no read, inputs move, output holds
            held = rd_data;
            set_live(i + 77);
            repeat (3) @(negedge clk);
            check("R8 hold while idle", rd_data, held);
            set_live(i);
        end
        // R9: unmapped addresses return zero and disturb nothing
        for (int a = MAPSZ; a < (1 << AW); a++) begin
            do_read(a, v);
            check("R9 unmapped reads zero", v, 8'h00);
        end
        for (int c = 0; c < NCH; c++) begin
            do_read(3*c + 1, v); check("R9 snapshot intact", v, model_snap[c][15:8]);
        end
        finish_run();
    end
endmodule